// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the oversampling enable that paces a UART transmitter and receiver. The system clock first passes a prescaler that either passes every cycle or one cycle in four. The result then drives a divider whose divisor has a 16-bit integer part N and a 4-bit fractional part F in sixteenths. Every group of sixteen sample ticks spans 16·N + F prescaled cycles. The F longer ticks, each N+1 cycles, are spread evenly across the group, and the others last N cycles.

The host loads the divisor through three byte-wide write strobes: integer low byte, integer high byte and fraction. It also drives a prescaler-select level and an oversampling-mode level. Besides the sample tick, the block emits a bit strobe on the last sample tick of each bit period, which is every 16 ticks in 16X mode and every 8 ticks in 8X mode. The divisor is computed as (clock / prescale) / (bit rate × oversampling factor). Any divisor write restarts the tick counter, the fractional phase and the prescaler.

Top module: `fbrg_top`

## Requirements
- R1: While `rst_n` is low both outputs are low. After reset the divisor is integer 1, fraction 0. With `presc_div4`=0, `sample_tick` is then high on every cycle, and with `mode_16x`=1, `bit_tick` first rises on the 16th cycle after release.
- R2: With fraction 0 and `presc_div4`=0, `sample_tick` is a one-cycle pulse every N cycles, where N = {high byte, low byte}.
- R3: With `presc_div4`=1, every tick interval is four times its length with `presc_div4`=0.
- R4: Number the ticks after a restart p = 0, 1, 2, … Tick p lasts N + e(p mod 16) prescaled cycles, where e(q) = floor((q+1)·F/16) − floor(q·F/16). The first tick therefore comes P·(N+e(0)) − 1 cycles after the restart edge, where P is the prescale factor.
- R5: With `mode_16x`=1, `bit_tick` coincides with sample ticks p where p mod 16 = 15, so the bit period is P·(16N+F) cycles.
- R6: With `mode_16x`=0, `bit_tick` coincides with ticks p where p mod 8 = 7. For an odd F the two alternating bit periods are P·(8N+floor(F/2)) and P·(8N+ceil(F/2)), with the longer period ending at p mod 16 = 15.
- R7: An integer divisor of 0 behaves as 1.
- R8: A fraction write keeps only `wr_data[3:0]`. Bits 7:4 have no effect on tick timing.
- R9: On any cycle with a write strobe high, `sample_tick` is low. The counter, the phase and the prescaler restart on that clock edge, so the first tick follows R4 counted from that edge.
- R10: `bit_tick` is high only together with `sample_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe, integer divisor low byte |
| wr_hi | input | 1 | Write strobe, integer divisor high byte |
| wr_frac | input | 1 | Write strobe, fraction (low 4 bits used) |
| wr_data | input | 8 | Write data |
| presc_div4 | input | 1 | 1: prescale by 4, 0: by 1 |
| mode_16x | input | 1 | 1: 16 ticks per bit, 0: 8 ticks per bit |
| sample_tick | output | 1 | Oversampling enable, one cycle wide |
| bit_tick | output | 1 | Bit-period strobe, one cycle wide |

## Verification
A divisor write can land in the same cycle as a sample tick that is due. The write must win: the tick is dropped and the count starts over. The bench provokes this with a divisor of 1, where a tick is due on every cycle. It raises a write strobe and checks that `sample_tick` is low in that cycle and high again in the first cycle after the edge. A second case rewrites a divisor of 10 part-way through a count and checks that the next tick arrives exactly nine cycles after the write edge, not at the point the old count would have reached.

// File: rtl/fbrg_pkg.sv
package fbrg_pkg;
  localparam int DATA_W  = 8;
  localparam int INT_W   = 2 * DATA_W;
  localparam int FRAC_W  = 4;
  localparam int CNT_W   = INT_W + 1;
  localparam int PRESC_R = 4;

  // integer divisor with zero mapped to one
  function automatic logic [INT_W-1:0] eff_int(input logic [INT_W-1:0] raw);
    return (raw == '0) ? INT_W'(1) : raw;
  endfunction

  // one when tick number ph of a 16-tick group is stretched by a cycle:
  // carry out of (ph*f mod 16) + f
  function automatic logic frac_extra(input logic [FRAC_W-1:0] ph,
                                      input logic [FRAC_W-1:0] f);
    logic [2*FRAC_W-1:0] prod;
    logic [FRAC_W:0]     acc;
    prod = {{FRAC_W{1'b0}}, ph} * {{FRAC_W{1'b0}}, f};
    acc  = {1'b0, prod[FRAC_W-1:0]} + {1'b0, f};
    return acc[FRAC_W];
  endfunction

  // length of one sample tick in prescaled cycles
  function automatic logic [CNT_W-1:0] tick_length(input logic [INT_W-1:0] n,
                                                   input logic extra);
    return {1'b0, n} + {{(CNT_W-1){1'b0}}, extra};
  endfunction

  // last sample of a bit: all phase bits set under the mode mask
  function automatic logic is_bit_point(input logic [FRAC_W-1:0] ph,
                                        input logic mode16);
    logic [FRAC_W-1:0] mask;
    mask = mode16 ? {FRAC_W{1'b1}} : {1'b0, {(FRAC_W-1){1'b1}}};
    return (ph & mask) == mask;
  endfunction
endpackage

// File: rtl/fbrg_regs.sv
module fbrg_regs
  import fbrg_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = INT_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_frac,
  input  logic [DW-1:0] wr_data,
  output logic [IW-1:0] div_int,
  output logic [FW-1:0] div_frac,
  output logic          wr_any
);
  logic [IW-1:0] int_q;
  logic [FW-1:0] frac_q;

  assign wr_any = wr_lo | wr_hi | wr_frac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= IW'(1);
      frac_q <= '0;
    end else begin
      if (wr_lo)   int_q[DW-1:0]  <= wr_data;
      if (wr_hi)   int_q[IW-1:DW] <= wr_data[IW-DW-1:0];
      if (wr_frac) frac_q         <= wr_data[FW-1:0];
    end
  end

  assign div_int  = int_q;
  assign div_frac = frac_q;
endmodule

// File: rtl/fbrg_prescaler.sv
module fbrg_prescaler #(
  parameter int RATIO = fbrg_pkg::PRESC_R
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_div,
  output logic pre_en
);
  generate
    if (RATIO <= 1) begin : g_bypass
      assign pre_en = 1'b1;
    end else begin : g_count
      localparam int PW = $clog2(RATIO);
      localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
      logic [PW-1:0] pc_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pc_q <= '0;
        else if (restart)       pc_q <= '0;
        else if (pc_q == LAST)  pc_q <= '0;
        else                    pc_q <= pc_q + PW'(1);
      end

      assign pre_en = sel_div ? (pc_q == LAST) : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/fbrg_divider.sv
module fbrg_divider
  import fbrg_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int FW = FRAC_W,
  parameter int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          pre_en,
  input  logic [IW-1:0] div_int,
  input  logic [FW-1:0] div_frac,
  input  logic          mode16,
  output logic          tick,
  output logic          bit_tick,
  output logic [CW-1:0] cnt_q,
  output logic [FW-1:0] phase_q,
  output logic [CW-1:0] tick_len
);
  logic [IW-1:0] n_eff;
  logic          extra;
  logic          hit;

  assign n_eff    = eff_int(div_int);
  assign extra    = frac_extra(phase_q, div_frac);
  assign tick_len = tick_length(n_eff, extra);
  assign hit      = pre_en && (cnt_q == tick_len - CW'(1));
  assign tick     = hit && !restart && rst_n;
  assign bit_tick = tick && is_bit_point(phase_q, mode16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (restart) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (pre_en) begin
      if (hit) begin
        cnt_q   <= '0;
        phase_q <= phase_q + FW'(1);
      end else begin
        cnt_q   <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fbrg_top.sv
module fbrg_top
  import fbrg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_frac,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              presc_div4,
  input  logic              mode_16x,
  output logic              sample_tick,
  output logic              bit_tick
);
  logic [INT_W-1:0]  div_int;
  logic [FRAC_W-1:0] div_frac;
  logic              wr_any;
  logic              pre_en;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] phase_q;
  logic [CNT_W-1:0]  tick_len;

  fbrg_regs #(.DW(DATA_W), .IW(INT_W), .FW(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_frac(wr_frac), .wr_data(wr_data), .div_int(div_int),
    .div_frac(div_frac), .wr_any(wr_any)
  );

  fbrg_prescaler #(.RATIO(PRESC_R)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(wr_any), .sel_div(presc_div4),
    .pre_en(pre_en)
  );

  fbrg_divider #(.IW(INT_W), .FW(FRAC_W), .CW(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(wr_any), .pre_en(pre_en),
    .div_int(div_int), .div_frac(div_frac), .mode16(mode_16x),
    .tick(sample_tick), .bit_tick(bit_tick), .cnt_q(cnt_q),
    .phase_q(phase_q), .tick_len(tick_len)
  );
endmodule

// File: rtl/fbrg_chk.sv
module fbrg_chk
  import fbrg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_any,
  input logic              pre_en,
  input logic              presc_sel,
  input logic              tick,
  input logic              bit_tick,
  input logic [FRAC_W-1:0] phase,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  tick_len
);
  // R1: outputs quiet in reset
  always_comb begin
    if (!rst_n) p_quiet_in_reset_r1: assert (!tick && !bit_tick);
  end

  p_bit_with_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> tick);

  p_no_tick_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> !tick);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (cnt == '0 && phase == '0));

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < tick_len);

  p_presc_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && presc_sel) |=> (!presc_sel || !pre_en));

  p_hold_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_en && !wr_any) |=> $stable(cnt));

  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase == $past(phase) + FRAC_W'(1)));
endmodule

bind fbrg_top fbrg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_any(wr_any), .pre_en(pre_en),
  .presc_sel(presc_div4), .tick(sample_tick), .bit_tick(bit_tick),
  .phase(phase_q), .cnt(cnt_q), .tick_len(tick_len)
);

// File: tb/fbrg_top_tb.sv
module fbrg_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_lo = 1'b0, wr_hi = 1'b0, wr_frac = 1'b0;
  logic [7:0] wr_data = '0;
  logic       presc_div4 = 1'b0;
  logic       mode_16x = 1'b1;
  logic       sample_tick, bit_tick;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #2 clk = ~clk;

  fbrg_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_frac(wr_frac), .wr_data(wr_data), .presc_div4(presc_div4),
    .mode_16x(mode_16x), .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  // fields: lo, hi, frac, presc_div4, mode_16x
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {8'd5,  8'd0, 8'h00, 1'b0, 1'b1},
    {8'd3,  8'd0, 8'h00, 1'b1, 1'b1},
    {8'd4,  8'd0, 8'h05, 1'b0, 1'b1},
    {8'd2,  8'd0, 8'hA7, 1'b0, 1'b1},
    {8'd0,  8'd0, 8'h00, 1'b0, 1'b1},
    {8'd3,  8'd0, 8'h03, 1'b1, 1'b0},
    {8'd2,  8'd1, 8'h09, 1'b0, 1'b1},
    {8'd1,  8'd0, 8'h0F, 1'b0, 1'b1},
    {8'd6,  8'd0, 8'h0A, 1'b0, 1'b0}
  };
  localparam int VREQ [NV] = '{2, 3, 4, 8, 7, 6, 2, 5, 6};

  function automatic string req_name(input int r);
    case (r)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // stretch of tick q, written as a difference of floors
  function automatic int ext(input int q, input int f);
    return ((q + 1) * f) / 16 - (q * f) / 16;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // raise a strobe for one cycle; returns at the first negedge after the edge
  task automatic wr(input int which, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_lo   = (which == 0);
    wr_hi   = (which == 1);
    wr_frac = (which == 2);
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0; wr_frac = 1'b0;
    #1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check(sample_tick === 1'b0 && bit_tick === 1'b0, "R1 quiet in reset",
          int'(sample_tick), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    begin
      int errs = 0;
      for (int k = 0; k < 20; k++) begin
        if (sample_tick !== 1'b1 || bit_tick !== (k == 15)) errs++;
        @(negedge clk); #1;
      end
      check(errs == 0, "R1 default divisor", errs, 0);
    end

    // table walk
    for (int i = 0; i < NV; i++) begin
      int lo, hi, fr, pr, n, f, nxt, p, errs;
      bit md;
      lo = int'(VEC[i][25:18]);
      hi = int'(VEC[i][17:10]);
      fr = int'(VEC[i][9:2]);
      pr = VEC[i][1] ? 4 : 1;
      md = VEC[i][0];
      @(negedge clk);
      presc_div4 = VEC[i][1];
      mode_16x   = md;
      wr(0, lo[7:0]);
      wr(1, hi[7:0]);
      wr(2, fr[7:0]);
      n = hi * 256 + lo;
      if (n == 0) n = 1;
      f = fr % 16;
      p = 0;
      errs = 0;
      nxt = pr * (n + ext(0, f)) - 1;
      for (int k = 0; p < 40; k++) begin
        bit et, eb;
        et = (k == nxt);
        eb = et && (md ? (p % 16 == 15) : (p % 8 == 7));
        if (sample_tick !== et || bit_tick !== eb) errs++;
        if (et) begin
          p++;
          nxt += pr * (n + ext(p % 16, f));
        end
        @(negedge clk); #1;
      end
      check(errs == 0, req_name(VREQ[i]), errs, 0);
    end

    // R9: write lands while a tick is due (divisor 1)
    presc_div4 = 1'b0;
    mode_16x   = 1'b1;
    wr(1, 8'd0);
    wr(2, 8'd0);
    wr(0, 8'd1);
    @(negedge clk);
    wr_lo = 1'b1; wr_data = 8'd1;
    #1;
    check(sample_tick === 1'b0, "R9 tick dropped on write", int'(sample_tick), 0);
    @(negedge clk);
    wr_lo = 1'b0;
    #1;
    check(sample_tick === 1'b1, "R9 tick right after write", int'(sample_tick), 1);

    // R9: mid-count rewrite restarts the count
    wr(0, 8'd10);
    repeat (4) @(negedge clk);
    wr(0, 8'd10);
    begin
      int k = 0;
      while (sample_tick !== 1'b1 && k < 100) begin
        @(negedge clk); #1; k++;
      end
      check(k == 9, "R9 restart latency", k, 9);
    end

    // R6: 8X jitter with odd fraction
    mode_16x = 1'b0;
    wr(0, 8'd3);
    wr(2, 8'd3);
    begin
      int t[3];
      int nb = 0;
      int e1 = 0, e2 = 0;
      for (int q = 8; q < 16; q++) e1 += 3 + ext(q, 3);
      for (int q = 0; q < 8; q++)  e2 += 3 + ext(q, 3);
      for (int k = 0; nb < 3 && k < 500; k++) begin
        if (bit_tick === 1'b1) begin t[nb] = k; nb++; end
        @(negedge clk); #1;
      end
      check(nb == 3 && t[0] == e2 - 1, "R6 first bit strobe", t[0], e2 - 1);
      check(t[1] - t[0] == e1, "R6 long bit period", t[1] - t[0], e1);
      check(t[2] - t[1] == e2, "R6 short bit period", t[2] - t[1], e2);
    end

    finish_run();
  end
endmodule